// File: doc/BRIEF.md
# Two-Address Cell Receive Port for a Shared Cell Bus

This block sits on the physical-layer side of a multi-PHY cell bus in the receive direction, where the physical layer sends cells up to the layer above. It serves two logical ports from one bus attachment. One port carries the fast data channel and the other carries the interleaved data channel. Each port has its own 5-bit address, taken from a configuration input. Each port keeps a small store of complete 53-byte cells. A local producer fills that store one byte at a time through a valid/ready push interface.

The master drives every bus signal on its own receive clock. A master polls a port by placing that port's address on the bus while the active-low enable is low. The port answers with its cell-available flag one cycle later. A master selects a port by placing the address on the bus while the enable is high and then pulling the enable low on the next cycle. The selected port then sends one byte per enabled cycle, each in the cycle after it samples the enable low. A start-of-cell flag marks byte 0 of each cell. The block drives the shared flag and data lines only when it owns them, and it signals this through separate output-enables. A pad ring outside the block turns these into tri-state drivers.

Top module: `mphy_rx_port`

## Requirements
- R1: After reset both output-enables are low, the start flag is low, and both ports report ready to accept fill bytes.
- R2: A poll is the bus address equal to a port's address while `rx_enb_n` is low. In the next cycle `rx_clav_oe` is high and `rx_clav` is 1 exactly when that port held at least one complete cell at the sampling edge.
- R3: If `rx_enb_n` is low and the address matches neither port, `rx_clav_oe` is low in the next cycle and `rx_clav` is 0. `rx_clav` is also 0 whenever `rx_clav_oe` is low.
- R4: A select is an address sampled with `rx_enb_n` high, followed by `rx_enb_n` low at the next edge. A matching address makes that port the source. A non-matching address leaves no source selected. The source's byte appears on `rx_data` with `rx_data_oe` high in the cycle after each edge at which `rx_enb_n` is sampled low, and this starts with the select edge itself.
- R5: `rx_soc` is 1 for byte offset 0 of a cell and 0 for offsets 1 to 52 and for idle cycles.
- R6: While `rx_enb_n` is high, no byte is sent and the port keeps its offset. Reselecting the same port resumes at the next unsent byte. Each port keeps its own offset, so a partial cell on one port survives a transfer from the other port.
- R7: After offset 52 is sent, the cell is released, and a poll at a later edge reports whether a further complete cell remains.
- R8: Each port delivers its cells in fill order and the bytes of each cell in push order.
- R9: A port holds at most NCELLS complete cells. Its `fill_ready` bit is low while it is full, and a byte offered while the bit is low is not stored.
- R10: If both configured addresses are equal, polls and selects resolve to the fast port (index 0, bits [7:0] of `fill_data`).
- R11: `rx_data_oe` stays low when no port is selected, or when the selected port has no complete cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the master |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_fast | input | 5 | Bus address of the fast channel port (index 0) |
| cfg_addr_intl | input | 5 | Bus address of the interleaved channel port (index 1) |
| fill_valid | input | 2 | Per-port push strobe, bit p for port p |
| fill_data | input | 16 | Push bytes, port p in bits [8p+7:8p] |
| fill_ready | output | 2 | Per-port space for another byte |
| rx_addr | input | 5 | Address bus from the master |
| rx_enb_n | input | 1 | Active-low transfer enable from the master |
| rx_clav | output | 1 | Cell-available answer to a poll |
| rx_clav_oe | output | 1 | Drive enable for `rx_clav` |
| rx_data | output | 8 | Cell byte |
| rx_soc | output | 1 | Start-of-cell marker |
| rx_data_oe | output | 1 | Drive enable for `rx_data` and `rx_soc` |

## Verification
The bench goes after the one-cycle gap between a select and its first byte. A design that used the enable edge only to latch the port would lose byte 0, or send it one cycle late. Pauses mid-cell with the same address held are exercised, along with reselecting the other port mid-cell. A design with one shared offset would resume the wrong byte or corrupt a partial cell. Polls landing on the very edge that sends byte 52 are exercised, as are full buffers with fill bytes still offered and an equal-address configuration. Each of these would show up as a wrong available flag, a lost or duplicated cell, or the interleaved port answering in place of the fast one.

// File: rtl/mphy_rx_pkg.sv
package mphy_rx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int ADDR_W     = 5;
  localparam int BYTE_W     = 8;
  localparam int NPORT      = 2;
  localparam int OFF_W      = $clog2(CELL_BYTES);
  localparam int PIDX_W     = (NPORT > 1) ? $clog2(NPORT) : 1;

  typedef logic [OFF_W-1:0] off_t;

  // final byte position of a cell
  function automatic logic off_last(off_t o);
    return o == off_t'(CELL_BYTES - 1);
  endfunction

  // next byte position, wrapping to zero after the final byte
  function automatic off_t off_step(off_t o);
    return off_last(o) ? '0 : o + off_t'(1);
  endfunction
endpackage

// File: rtl/mphy_cell_store.sv
module mphy_cell_store
  import mphy_rx_pkg::*;
#(
  parameter  int NCELLS = 2,
  localparam int CNT_W  = $clog2(NCELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [BYTE_W-1:0] fill_data,
  output logic              fill_ready,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_first,
  output logic              rd_done,
  output logic              wr_done,
  output logic              cell_avail,
  output logic [CNT_W-1:0]  cell_cnt
);
  localparam int PTR_W = (NCELLS > 1) ? $clog2(NCELLS) : 1;
  localparam int DEPTH = NCELLS * CELL_BYTES;
  localparam int IDX_W = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  off_t              wr_off, rd_off;
  logic              push;

  function automatic logic [PTR_W-1:0] ptr_step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(NCELLS - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] flat_idx(logic [PTR_W-1:0] p, off_t o);
    return IDX_W'(int'(p) * CELL_BYTES + int'(o));
  endfunction

  assign fill_ready = cell_cnt < CNT_W'(NCELLS);
  assign push       = fill_valid && fill_ready;
  assign wr_done    = push && off_last(wr_off);
  assign rd_done    = rd_en && off_last(rd_off);
  assign cell_avail = cell_cnt != '0;
  assign rd_byte    = mem[flat_idx(rd_ptr, rd_off)];
  assign rd_first   = rd_off == '0;

  always_ff @(posedge clk) begin
    if (push) mem[flat_idx(wr_ptr, wr_off)] <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      wr_off   <= '0;
      rd_off   <= '0;
      cell_cnt <= '0;
    end else begin
      if (push) begin
        wr_off <= off_step(wr_off);
        if (wr_done) wr_ptr <= ptr_step(wr_ptr);
      end
      if (rd_en) begin
        rd_off <= off_step(rd_off);
        if (rd_done) rd_ptr <= ptr_step(rd_ptr);
      end
      case ({wr_done, rd_done})
        2'b10:   cell_cnt <= cell_cnt + CNT_W'(1);
        2'b01:   cell_cnt <= cell_cnt - CNT_W'(1);
        default: cell_cnt <= cell_cnt;
      endcase
    end
  end
endmodule

// File: rtl/mphy_bus_ctrl.sv
module mphy_bus_ctrl
  import mphy_rx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       rx_addr,
  input  logic                    rx_enb_n,
  input  logic [NPORT*ADDR_W-1:0] port_addr,
  input  logic [NPORT-1:0]        cell_avail,
  output logic                    poll_hit,
  output logic                    poll_avail,
  output logic                    sel_commit,
  output logic                    xfer,
  output logic [NPORT-1:0]        rd_en,
  output logic [PIDX_W-1:0]       act_idx
);
  logic              hit;
  logic [PIDX_W-1:0] hit_idx;
  logic              prev_enb_n, prev_hit;
  logic [PIDX_W-1:0] prev_idx;
  logic              sel_v;
  logic [PIDX_W-1:0] sel_idx;
  logic              act_v;

  // lowest index wins, so the fast port takes priority on equal addresses
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (rx_addr == port_addr[p*ADDR_W +: ADDR_W]) begin
        hit     = 1'b1;
        hit_idx = PIDX_W'(p);
      end
    end
  end

  assign poll_hit   = !rx_enb_n && hit;
  assign poll_avail = cell_avail[hit_idx];
  assign sel_commit = !rx_enb_n && prev_enb_n;
  assign act_v      = sel_commit ? prev_hit : sel_v;
  assign act_idx    = sel_commit ? prev_idx : sel_idx;
  assign xfer       = !rx_enb_n && act_v && cell_avail[act_idx];

  always_comb begin
    rd_en = '0;
    rd_en[act_idx] = xfer;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_enb_n <= 1'b1;
      prev_hit   <= 1'b0;
      prev_idx   <= '0;
      sel_v      <= 1'b0;
      sel_idx    <= '0;
    end else begin
      prev_enb_n <= rx_enb_n;
      prev_hit   <= hit;
      prev_idx   <= hit_idx;
      if (sel_commit) begin
        sel_v   <= prev_hit;
        sel_idx <= prev_idx;
      end
    end
  end
endmodule

// File: rtl/mphy_rx_port.sv
module mphy_rx_port
  import mphy_rx_pkg::*;
#(
  parameter int NCELLS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cfg_addr_fast,
  input  logic [ADDR_W-1:0]       cfg_addr_intl,
  input  logic [NPORT-1:0]        fill_valid,
  input  logic [NPORT*BYTE_W-1:0] fill_data,
  output logic [NPORT-1:0]        fill_ready,
  input  logic [ADDR_W-1:0]       rx_addr,
  input  logic                    rx_enb_n,
  output logic                    rx_clav,
  output logic                    rx_clav_oe,
  output logic [BYTE_W-1:0]       rx_data,
  output logic                    rx_soc,
  output logic                    rx_data_oe
);
  localparam int CNT_W = $clog2(NCELLS + 1);

  logic [BYTE_W-1:0]      st_byte [NPORT];
  logic [NPORT-1:0]       st_first, st_avail, rd_en, rd_done, wr_done;
  logic [NPORT*CNT_W-1:0] cnt_bus;
  logic                   poll_hit, poll_avail, sel_commit, xfer;
  logic [PIDX_W-1:0]      act_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mphy_cell_store #(.NCELLS(NCELLS)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_valid (fill_valid[p]),
      .fill_data  (fill_data[p*BYTE_W +: BYTE_W]),
      .fill_ready (fill_ready[p]),
      .rd_en      (rd_en[p]),
      .rd_byte    (st_byte[p]),
      .rd_first   (st_first[p]),
      .rd_done    (rd_done[p]),
      .wr_done    (wr_done[p]),
      .cell_avail (st_avail[p]),
      .cell_cnt   (cnt_bus[p*CNT_W +: CNT_W])
    );
  end

  mphy_bus_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_addr    (rx_addr),
    .rx_enb_n   (rx_enb_n),
    .port_addr  ({cfg_addr_intl, cfg_addr_fast}),
    .cell_avail (st_avail),
    .poll_hit   (poll_hit),
    .poll_avail (poll_avail),
    .sel_commit (sel_commit),
    .xfer       (xfer),
    .rd_en      (rd_en),
    .act_idx    (act_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_clav    <= 1'b0;
      rx_clav_oe <= 1'b0;
      rx_data    <= '0;
      rx_soc     <= 1'b0;
      rx_data_oe <= 1'b0;
    end else begin
      rx_clav_oe <= poll_hit;
      rx_clav    <= poll_hit && poll_avail;
      rx_data_oe <= xfer;
      rx_soc     <= xfer && st_first[act_idx];
      if (xfer) rx_data <= st_byte[act_idx];
    end
  end
endmodule

// File: rtl/mphy_rx_port_chk.sv
module mphy_rx_port_chk
  import mphy_rx_pkg::*;
#(
  parameter  int NCELLS = 2,
  localparam int CNT_W  = $clog2(NCELLS + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      rx_addr,
  input logic                   rx_enb_n,
  input logic [ADDR_W-1:0]      cfg_addr_fast,
  input logic [ADDR_W-1:0]      cfg_addr_intl,
  input logic                   poll_hit,
  input logic                   xfer,
  input logic                   rx_clav,
  input logic                   rx_clav_oe,
  input logic                   rx_soc,
  input logic                   rx_data_oe,
  input logic [NPORT-1:0]       rd_done,
  input logic [NPORT-1:0]       wr_done,
  input logic [NPORT*CNT_W-1:0] cnt_bus
);
  assert_poll_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> rx_clav_oe);

  assert_foreign_poll_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enb_n && rx_addr != cfg_addr_fast && rx_addr != cfg_addr_intl) |=> !rx_clav_oe);

  assert_clav_needs_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clav |-> rx_clav_oe);

  assert_send_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> !rx_enb_n);

  assert_soc_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_soc |-> rx_data_oe);

  assert_pause_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enb_n |=> !rx_data_oe);

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    assert_cell_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_bus[p*CNT_W +: CNT_W] <= CNT_W'(NCELLS));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done[p] && !wr_done[p]) |=>
        cnt_bus[p*CNT_W +: CNT_W] == $past(cnt_bus[p*CNT_W +: CNT_W]) - CNT_W'(1));
  end
endmodule

bind mphy_rx_port mphy_rx_port_chk #(.NCELLS(NCELLS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_addr       (rx_addr),
  .rx_enb_n      (rx_enb_n),
  .cfg_addr_fast (cfg_addr_fast),
  .cfg_addr_intl (cfg_addr_intl),
  .poll_hit      (poll_hit),
  .xfer          (xfer),
  .rx_clav       (rx_clav),
  .rx_clav_oe    (rx_clav_oe),
  .rx_soc        (rx_soc),
  .rx_data_oe    (rx_data_oe),
  .rd_done       (rd_done),
  .wr_done       (wr_done),
  .cnt_bus       (cnt_bus)
);

// File: tb/mphy_rx_port_tb.sv
module mphy_rx_port_tb;
  localparam int NC   = 2;
  localparam int CB   = 53;
  localparam logic [4:0] A_FAST  = 5'h03;
  localparam logic [4:0] A_INTL  = 5'h11;
  localparam logic [4:0] A_OTHER = 5'h1e;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_addr_fast = A_FAST;
  logic [4:0]  cfg_addr_intl = A_INTL;
  logic [1:0]  fill_valid = '0;
  logic [15:0] fill_data = '0;
  logic [1:0]  fill_ready;
  logic [4:0]  rx_addr = A_OTHER;
  logic        rx_enb_n = 1'b1;
  logic        rx_clav, rx_clav_oe, rx_soc, rx_data_oe;
  logic [7:0]  rx_data;

  always #2.5 clk = ~clk;

  mphy_rx_port #(.NCELLS(NC)) u_dut (.*);

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "reset";
  bit    fill_on [2];
  bit    done = 1'b0;

  // reference model state
  logic [7:0] mq [2][$];
  int         m_off [2];
  logic [7:0] seq [2];
  bit m_prev_enb = 1, m_prev_hit = 0, m_sel_v = 0;
  int m_prev_idx = 0, m_sel_idx = 0;
  bit e_clav = 0, e_clav_oe = 0, e_soc = 0, e_doe = 0;
  logic [7:0] e_data = '0;

  function automatic bit m_avail(int p);
    return mq[p].size() >= CB;
  endfunction
  function automatic bit m_ready(int p);
    return (mq[p].size() / CB) < NC;
  endfunction

  initial begin
    seq[0] = 8'h00;
    seq[1] = 8'h80;
    fill_on[0] = 0;
    fill_on[1] = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        mq[p].delete();
        m_off[p] = 0;
      end
      m_prev_enb = 1; m_prev_hit = 0; m_prev_idx = 0;
      m_sel_v = 0; m_sel_idx = 0;
      e_clav = 0; e_clav_oe = 0; e_soc = 0; e_doe = 0; e_data = '0;
    end else begin
      bit av [2];
      bit rd [2];
      bit hit, commit, act_v, x;
      int idx, act_i;
      for (int p = 0; p < 2; p++) begin
        av[p] = m_avail(p);
        rd[p] = m_ready(p);
      end
      hit = 0; idx = 0;
      if (rx_addr == cfg_addr_fast) begin hit = 1; idx = 0; end
      else if (rx_addr == cfg_addr_intl) begin hit = 1; idx = 1; end
      e_clav_oe = !rx_enb_n && hit;
      e_clav    = e_clav_oe && av[idx];
      commit = !rx_enb_n && m_prev_enb;
      act_v  = commit ? m_prev_hit : m_sel_v;
      act_i  = commit ? m_prev_idx : m_sel_idx;
      if (commit) begin m_sel_v = m_prev_hit; m_sel_idx = m_prev_idx; end
      x = !rx_enb_n && act_v && av[act_i];
      e_doe = x;
      e_soc = 0;
      if (x) begin
        e_data = mq[act_i][m_off[act_i]];
        e_soc  = (m_off[act_i] == 0);
        if (m_off[act_i] == CB - 1) begin
          repeat (CB) void'(mq[act_i].pop_front());
          m_off[act_i] = 0;
        end else m_off[act_i]++;
      end
      for (int p = 0; p < 2; p++)
        if (fill_valid[p] && rd[p]) begin
          mq[p].push_back(fill_data[p*8 +: 8]);
          seq[p] = seq[p] + 8'd1;
        end
      m_prev_enb = rx_enb_n; m_prev_hit = hit; m_prev_idx = idx;
    end
  end

  // fill driver
  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      fill_valid[p] = fill_on[p] && (($urandom % 4) != 0);
      fill_data[p*8 +: 8] = seq[p];
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rx_clav_oe == e_clav_oe, "R3 clav_oe", rx_clav_oe, e_clav_oe);
      check(rx_clav == e_clav, "R2 clav", rx_clav, e_clav);
      check(rx_data_oe == e_doe, "R4 R11 data_oe", rx_data_oe, e_doe);
      check(rx_soc == e_soc, "R5 soc", rx_soc, e_soc);
      if (e_doe) check(rx_data == e_data, "R8 data", rx_data, e_data);
      check(fill_ready[0] == m_ready(0), "R9 ready fast", fill_ready[0], m_ready(0));
      check(fill_ready[1] == m_ready(1), "R9 ready intl", fill_ready[1], m_ready(1));
    end
  end

  task automatic drive(logic [4:0] a, logic en_n);
    @(negedge clk);
    rx_addr  = a;
    rx_enb_n = en_n;
  endtask

  task automatic rand_bus(int n);
    for (int i = 0; i < n; i++) begin
      int r;
      r = $urandom % 3;
      drive(r == 0 ? A_FAST : (r == 1 ? A_INTL : A_OTHER), ($urandom % 3) == 0);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog [%s] run did not end", phase);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs and ready after reset
    check(rx_clav_oe == 0 && rx_data_oe == 0 && rx_soc == 0, "R1 idle", {rx_clav_oe, rx_data_oe, rx_soc}, 0);
    check(fill_ready == 2'b11, "R1 ready", fill_ready, 2'b11);

    phase = "R2 R3 empty polls";
    drive(A_FAST, 0); drive(A_INTL, 0); drive(A_OTHER, 0); drive(A_OTHER, 1);

    phase = "R11 select with no cell";
    drive(A_FAST, 1); drive(A_OTHER, 0); drive(A_OTHER, 0); drive(A_OTHER, 1);

    phase = "R9 fill to full";
    fill_on[0] = 1; fill_on[1] = 1;
    repeat (400) drive(A_OTHER, 1);

    phase = "R2 R3 full polls";
    drive(A_FAST, 0); drive(A_INTL, 0); drive(A_OTHER, 0); drive(A_OTHER, 1);

    phase = "R4 R5 R7 whole cell fast";
    drive(A_FAST, 1);
    for (int i = 0; i < CB + 2; i++) drive((i % 2) ? A_FAST : A_OTHER, 0);
    drive(A_OTHER, 1);

    phase = "R6 pause and resume intl";
    drive(A_INTL, 1);
    repeat (20) drive(A_OTHER, 0);
    repeat (5) drive(A_INTL, 1);
    repeat (10) drive(A_OTHER, 0);
    phase = "R6 switch to fast mid-cell";
    drive(A_FAST, 1);
    repeat (30) drive(A_OTHER, 0);
    drive(A_INTL, 1);
    repeat (60) drive(A_INTL, 0);
    drive(A_OTHER, 1);

    phase = "R8 random traffic";
    rand_bus(4000);

    phase = "R10 equal addresses";
    drive(A_OTHER, 1);
    cfg_addr_intl = A_FAST;
    rand_bus(800);
    drive(A_OTHER, 1);
    cfg_addr_intl = A_INTL;

    phase = "R7 drain";
    fill_on[0] = 0; fill_on[1] = 0;
    rand_bus(2000);
    drive(A_OTHER, 1);
    @(negedge clk);
    finish_run();
  end
endmodule